// File: doc/BRIEF.md
# Feedback Edge Phase Build-out Selector

This block is the feedback divider of a PLL with one extra ability: on request it re-aligns the feedback clock to a new reference phase. It does this by choosing which oscillator cycle starts a feedback period. With no request pending it divides the oscillator clock by a run-time ratio N. Each feedback period begins with a rising edge of the feedback clock.

A switching sequence raises a one-cycle build-out request while the phase detector is held off. The block then waits for the next reference edge, which arrives already synchronised to the oscillator clock. It measures how many oscillator cycles that edge lies after the most recent feedback edge, and picks the smallest whole-cycle correction. The correction lengthens or shortens the period that follows the current one. A one-cycle completion pulse marks the first feedback edge that lands on the new reference phase, and the sequence may re-enable its detector at that point. Sub-cycle phase errors are left to the loop.

Top module: `pbo_edge_selector`

## Requirements
- R1: While reset is held, `fb_clk` is 1 and `bo_done` is 0. The first cycle after release is the start of a feedback period.
- R2: With no build-out in progress, a rising edge of `fb_clk` (a feedback edge) occurs every `div_ratio` oscillator cycles.
- R3: Within each period `fb_clk` is high for the first floor(N/2) cycles and low for the rest, which gives a 50% duty cycle for even N.
- R4: After a request, the offset k is taken at the first `ref_edge` that follows. k is the number of oscillator cycles from the latest feedback edge to that reference edge, so 0 <= k < N.
- R5: When k <= floor(N/2), the period after the one in progress is lengthened to N+k cycles. This includes k = 0, which leaves the period at N.
- R6: When k > floor(N/2), the period after the one in progress is shortened to k cycles, which is N-k fewer than N.
- R7: After the corrected period the block divides by N again, and its feedback edges fall on the cycles of the reference edge phase.
- R8: `bo_done` is high for exactly one cycle, the cycle of the first re-aligned feedback edge.
- R9: A request is taken only when no build-out is in progress. A `ref_edge` is ignored unless a request is waiting for it, and that includes a `ref_edge` in the same cycle as the request. Ignored pulses leave the feedback waveform unchanged.
- R10: If the captured reference edge falls on the last cycle of a period, the correction applies to the period that starts in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_edge | input | 1 | One-cycle pulse marking a reference edge, synchronous to `osc_clk` |
| bo_req | input | 1 | One-cycle build-out request |
| div_ratio | input | DIV_W | Divide ratio N, at least 2 |
| fb_clk | output | 1 | Feedback clock to the phase detector |
| bo_done | output | 1 | One-cycle pulse on the first re-aligned feedback edge |

## Verification
Two events can fall in the same cycle: the capture of the offset and the wrap of the divider that ends the current period. This happens when the reference edge arrives on the last count of a period. In that case the corrected length must be loaded at once instead of on a later wrap. The sweep covers every offset for every ratio from 2 to 8, and so reaches this case for each ratio (k = N-1). The whole feedback waveform and the completion pulse are then compared cycle by cycle against edge times worked out from N and k. A stray reference pulse before the request, a repeated request during the build-out, and reference pulses after completion are added to show that none of them disturbs the waveform.

// File: rtl/pbo_pkg.sv
package pbo_pkg;
   typedef enum logic [1:0] {
      ST_IDLE      = 2'd0,
      ST_WAIT_REF  = 2'd1,
      ST_WAIT_WRAP = 2'd2,
      ST_SLIP      = 2'd3
   } pbo_state_e;
endpackage

// File: rtl/pbo_slip_calc.sv
module pbo_slip_calc #(
   parameter int DIV_W       = 8,
   parameter bit TIE_SHORTEN = 1'b0,
   localparam int CW         = DIV_W + 1
) (
   input  logic [CW-1:0]    phase_ofs,
   input  logic [DIV_W-1:0] ratio,
   output logic [CW-1:0]    slip_len
);
   logic [CW-1:0] ratio_w;
   logic [CW-1:0] half_w;
   logic          shorten;

   assign ratio_w = {1'b0, ratio};
   assign half_w  = ratio_w >> 1;

   generate
      if (TIE_SHORTEN) begin : g_tie_short
         assign shorten = (phase_ofs >= half_w) && (phase_ofs != '0);
      end else begin : g_tie_long
         assign shorten = (phase_ofs > half_w);
      end
   endgenerate

   // R5/R6: the period is either stretched by k or cut to k cycles
   assign slip_len = shorten ? phase_ofs : (ratio_w + phase_ofs);
endmodule

// File: rtl/pbo_divider.sv
module pbo_divider #(
   parameter int DIV_W = 8,
   localparam int CW   = DIV_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] ratio,
   input  logic             slip_active,
   input  logic [CW-1:0]    slip_len,
   output logic [CW-1:0]    cnt,
   output logic             wrap,
   output logic             fb_clk
);
   logic [CW-1:0] plen;
   logic [CW-1:0] half_w;

   assign plen   = slip_active ? slip_len : {1'b0, ratio};
   assign half_w = {1'b0, ratio} >> 1;
   assign wrap   = (cnt >= plen - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (wrap) cnt <= '0;
      else cnt <= cnt + CW'(1);
   end

   assign fb_clk = (cnt < half_w);
endmodule

// File: rtl/pbo_ctrl.sv
module pbo_ctrl
   import pbo_pkg::*;
#(
   parameter int DIV_W = 8,
   localparam int CW   = DIV_W + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bo_req,
   input  logic          ref_edge,
   input  logic          wrap,
   input  logic [CW-1:0] calc_len,
   output pbo_state_e    state,
   output logic [CW-1:0] slip_len_q,
   output logic          slip_active,
   output logic          done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         slip_len_q <= '0;
         done       <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: if (bo_req) state <= ST_WAIT_REF;
            ST_WAIT_REF: if (ref_edge) begin
               slip_len_q <= calc_len;
               state      <= wrap ? ST_SLIP : ST_WAIT_WRAP; // R10 same-cycle wrap
            end
            ST_WAIT_WRAP: if (wrap) state <= ST_SLIP;
            ST_SLIP: if (wrap) begin
               state <= ST_IDLE;
               done  <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign slip_active = (state == ST_SLIP);
endmodule

// File: rtl/pbo_edge_selector.sv
module pbo_edge_selector
   import pbo_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter bit TIE_SHORTEN = 1'b0
) (
   input  logic             osc_clk,
   input  logic             rst_n,
   input  logic             ref_edge,
   input  logic             bo_req,
   input  logic [DIV_W-1:0] div_ratio,
   output logic             fb_clk,
   output logic             bo_done
);
   localparam int CW = DIV_W + 1;

   generate
      if (DIV_W < 2 || DIV_W > 16) begin : g_bad_width
         $error("pbo_edge_selector: DIV_W must be within 2..16");
      end
   endgenerate

   pbo_state_e    state;
   logic [CW-1:0] cnt;
   logic [CW-1:0] calc_len;
   logic [CW-1:0] slip_len_q;
   logic          slip_active;
   logic          wrap;

   pbo_slip_calc #(.DIV_W(DIV_W), .TIE_SHORTEN(TIE_SHORTEN)) u_calc (
      .phase_ofs (cnt),
      .ratio     (div_ratio),
      .slip_len  (calc_len)
   );

   pbo_divider #(.DIV_W(DIV_W)) u_div (
      .clk         (osc_clk),
      .rst_n       (rst_n),
      .ratio       (div_ratio),
      .slip_active (slip_active),
      .slip_len    (slip_len_q),
      .cnt         (cnt),
      .wrap        (wrap),
      .fb_clk      (fb_clk)
   );

   pbo_ctrl #(.DIV_W(DIV_W)) u_ctrl (
      .clk         (osc_clk),
      .rst_n       (rst_n),
      .bo_req      (bo_req),
      .ref_edge    (ref_edge),
      .wrap        (wrap),
      .calc_len    (calc_len),
      .state       (state),
      .slip_len_q  (slip_len_q),
      .slip_active (slip_active),
      .done        (bo_done)
   );
endmodule

// File: rtl/pbo_edge_selector_chk.sv
module pbo_edge_selector_chk
   import pbo_pkg::*;
#(
   parameter int DIV_W = 8,
   localparam int CW   = DIV_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bo_req,
   input logic             ref_edge,
   input logic [DIV_W-1:0] div_ratio,
   input logic             fb_clk,
   input logic             bo_done,
   input logic [CW-1:0]    cnt,
   input pbo_state_e       state,
   input logic [CW-1:0]    slip_len
);
   logic [CW-1:0] n_w;
   logic [CW-1:0] h_w;
   assign n_w = {1'b0, div_ratio};
   assign h_w = n_w >> 1;

   p_done_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bo_done |-> (fb_clk && !$past(fb_clk)));

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bo_done |=> !bo_done);

   p_plain_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_SLIP && cnt == n_w - CW'(1)) |=> (cnt == '0));

   p_slip_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SLIP) |-> (slip_len >= h_w && slip_len <= n_w + h_w));

   p_req_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !bo_req) |=> (state == ST_IDLE));

   p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT_REF && ref_edge) |=> (state == ST_WAIT_WRAP || state == ST_SLIP));
endmodule

bind pbo_edge_selector pbo_edge_selector_chk #(.DIV_W(DIV_W)) u_chk (
   .clk       (osc_clk),
   .rst_n     (rst_n),
   .bo_req    (bo_req),
   .ref_edge  (ref_edge),
   .div_ratio (div_ratio),
   .fb_clk    (fb_clk),
   .bo_done   (bo_done),
   .cnt       (cnt),
   .state     (state),
   .slip_len  (slip_len_q)
);

// File: tb/pbo_edge_selector_bench.sv
`timescale 1ns/1ps
module pbo_edge_selector_bench;
   localparam int DIV_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ref_edge = 1'b0;
   logic             bo_req = 1'b0;
   logic [DIV_W-1:0] div_ratio = DIV_W'(4);
   logic             fb_clk;
   logic             bo_done;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   pbo_edge_selector #(.DIV_W(DIV_W)) u_pbo_edge_selector (
      .osc_clk   (clk),
      .rst_n     (rst_n),
      .ref_edge  (ref_edge),
      .bo_req    (bo_req),
      .div_ratio (div_ratio),
      .fb_clk    (fb_clk),
      .bo_done   (bo_done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_case(input int n, input int k);
      int t, e1, len, d, endc, last, first_bad, bad_act, bad_exp;
      int done_seen;
      bit exp_fb;
      string tag;
      t    = 2 * n + k;
      e1   = t + n - k;
      len  = (k > n / 2) ? k : n + k;   // R5 / R6
      d    = e1 + len;
      endc = d + 3 * n;
      first_bad = -1; bad_act = 0; bad_exp = 0; done_seen = -1;

      rst_n = 1'b0; bo_req = 1'b0; ref_edge = 1'b0; div_ratio = DIV_W'(n);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(fb_clk == 1'b1 && bo_done == 1'b0, "R1", $sformatf("reset n=%0d", n),
            {fb_clk, bo_done}, 2);
      rst_n = 1'b1;

      for (int c = 0; c <= endc; c++) begin
         if (c < e1) last = (c / n) * n;
         else if (c < d) last = e1;
         else last = d + ((c - d) / n) * n;
         exp_fb = ((c - last) < n / 2);
         if (first_bad < 0 && fb_clk !== exp_fb) begin
            first_bad = c; bad_act = int'(fb_clk); bad_exp = int'(exp_fb);
         end
         if (bo_done === 1'b1 && done_seen < 0) done_seen = c;
         else if (bo_done === 1'b1) done_seen = -2;  // more than one pulse
         // stray ref before request, request, capture, repeat request, refs after done
         bo_req   = (c == 1) || (c == t + 1);
         ref_edge = (c == 0) || (c == t) || (c == d) || (c == d + n);
         @(posedge clk);
         @(negedge clk);
      end
      bo_req = 1'b0; ref_edge = 1'b0;

      if (first_bad < 0) tag = "R2 R3";
      else if (first_bad < e1) tag = "R2 R3 R9";
      else if (first_bad < d) tag = (k > n / 2) ? "R6" : "R5";
      else tag = "R7 R9";
      if (k == n - 1) tag = {tag, " R10"};
      check(first_bad < 0, tag,
            $sformatf("fb_clk n=%0d k=%0d cycle %0d", n, k, first_bad), bad_act, bad_exp);
      check(done_seen == d, "R4 R8", $sformatf("done cycle n=%0d k=%0d", n, k),
            done_seen, d);
   endtask

   initial begin
      for (int n = 2; n <= 8; n++)
         for (int k = 0; k < n; k++)
            run_case(n, k);
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule